// File: doc/BRIEF.md
# Serial Configuration Slave Port

This block is the slave side of a four-wire byte-framed configuration link. An external controller drives a serial clock, an active-low select and a data line. The block answers on a data-out line whose driver it enables only when it has something to return. Every transfer opens with one command byte. That byte carries the direction, how many data bytes follow, and the register index to start from. After it come one to eight data bytes: the controller supplies them for a write, and the block shifts them back for a read. The register file itself sits outside the block and is reached through a plain strobe interface.

All logic runs on the system clock. The three link inputs pass through a synchronizer, and the serial clock edges are found by comparing successive synchronized samples. The serial clock must therefore run well below half the system clock; at 100 MHz this comfortably covers an 8.192 MHz link with an irregular duty cycle. The register-file port applies no back-pressure. The file must accept a write strobe in any cycle, and it must present read data on the cycle after the read strobe.

Top module: `sercfg_port`

## Requirements
- R1: During and after reset, `sdo_oe`, `sdo`, `wr_en` and `rd_en` are all low.
- R2: In the command byte, bit 7 = 1 means read and 0 means write, bits 6:4 hold the data byte count minus one, and bits 3:0 hold the first register index.
- R3: `sdi` is sampled on each rising edge of `sck` while `csn` is low, and bytes arrive most significant bit first.
- R4: A write data byte reaches the register file only once all eight of its bits have been sampled. Bits of an unfinished byte are dropped when `csn` rises.
- R5: A completed write byte is issued as a single-cycle `wr_en` pulse after the next rising `sck` edge. If that edge comes after `csn` has risen, the write is still issued there; without it, the write waits.
- R6: Each further data byte in a transfer uses the next register index, wrapping from 15 to 0.
- R7: A read command, or each completed read byte with more still to go, raises a one-cycle `rd_en` with the index of the next byte. `rd_data` is taken on the following cycle.
- R8: Read data leaves on `sdo` most significant bit first and changes only after a falling `sck` edge. The first bit appears on the falling edge that ends the command byte.
- R9: `sdo_oe` is low during the command byte and whenever `csn` is high. It goes high when the first read byte is loaded.
- R10: Once a command is decoded as a read, or once the stated byte count has been used up, further `sdi` bits cause no write and are not taken as a command.
- R11: Raising `csn` at any point ends the transfer. The next low period of `csn` starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the controller |
| csn | input | 1 | Active-low select; high aborts and idles the port |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Driver enable for the external tri-state buffer on `sdo` |
| wr_en | output | 1 | Register write strobe, one cycle |
| wr_addr | output | 4 | Register index for the write |
| wr_data | output | 8 | Byte to write |
| rd_en | output | 1 | Register read strobe, one cycle |
| rd_addr | output | 4 | Register index for the read |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |

## Verification
The transfers used are:
- a single-byte write closed by a trailing clock, which confirms the command field decode and the bit order;
- a three-byte write that crosses index 15, which exposes the address wrap;
- a write left without a trailing clock, which must stay pending until the first edge of the next transfer;
- a four-byte read with junk on `sdi`, which separates correct read-back from any leakage of input into writes;
- a write padded beyond its count;
- aborts in the middle of a command, a data byte and a read, which show that partial bytes are dropped and that the output driver turns off.

A behavioural model in the bench predicts every strobe and every returned bit at each serial edge.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_WR   = 2'd1,
    PH_RD   = 2'd2,
    PH_DONE = 2'd3
  } phase_e;
endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // STAGES must be at least 2
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= {STAGES{RST_VAL}};
    else        st <= {st[STAGES-2:0], d};
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sercfg_rx.sv
module sercfg_rx #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rise,
  input  logic              din,
  output logic              byte_ok,
  output logic [BYTE_W-1:0] byte_q,
  output logic [CNT_W-1:0]  bit_idx
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      cnt     <= '0;
      byte_ok <= 1'b0;
      byte_q  <= '0;
    end else begin
      byte_ok <= 1'b0;
      if (clr) begin
        sh  <= '0;
        cnt <= '0;
      end else if (rise) begin
        sh  <= {sh[BYTE_W-2:0], din};
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        if (cnt == LAST) begin
          byte_ok <= 1'b1;
          byte_q  <= {sh[BYTE_W-2:0], din};
        end
      end
    end
  end

  assign bit_idx = cnt;
endmodule

// File: rtl/sercfg_seq.sv
module sercfg_seq
  import sercfg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8,
  localparam int LEN_W = BYTE_W - 1 - ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rise,
  input  logic              byte_ok,
  input  logic [BYTE_W-1:0] byte_q,
  output phase_e            phase,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);
  logic              cmd_rd;
  logic [LEN_W-1:0]  cmd_len;
  logic [ADDR_W-1:0] cmd_addr;

  assign cmd_rd   = byte_q[BYTE_W-1];
  assign cmd_len  = byte_q[BYTE_W-2 -: LEN_W];
  assign cmd_addr = byte_q[ADDR_W-1:0];

  logic [ADDR_W-1:0] addr;
  logic [LEN_W-1:0]  left;
  logic              pend;
  logic [ADDR_W-1:0] pend_addr;
  logic [BYTE_W-1:0] pend_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      addr      <= '0;
      left      <= '0;
      pend      <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
    end else begin
      wr_en <= 1'b0;
      rd_en <= 1'b0;
      // a staged byte goes out on the serial edge after it completed
      if (rise && pend) begin
        wr_en   <= 1'b1;
        wr_addr <= pend_addr;
        wr_data <= pend_data;
        pend    <= 1'b0;
      end
      if (clr) begin
        phase <= PH_CMD;
      end else if (byte_ok) begin
        unique case (phase)
          PH_CMD: begin
            addr <= cmd_addr;
            left <= cmd_len;
            if (cmd_rd) begin
              phase   <= PH_RD;
              rd_en   <= 1'b1;
              rd_addr <= cmd_addr;
            end else begin
              phase <= PH_WR;
            end
          end
          PH_WR: begin
            pend      <= 1'b1;
            pend_addr <= addr;
            pend_data <= byte_q;
            addr      <= addr + 1'b1;
            if (left == '0) phase <= PH_DONE;
            else            left  <= left - 1'b1;
          end
          PH_RD: begin
            if (left == '0) begin
              phase <= PH_DONE;
            end else begin
              left    <= left - 1'b1;
              addr    <= addr + 1'b1;
              rd_en   <= 1'b1;
              rd_addr <= addr + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sercfg_tx.sv
module sercfg_tx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fall,
  input  logic              load_en,
  input  logic              bit_zero,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sdo,
  output logic              sdo_oe
);
  logic              take;
  logic [BYTE_W-1:0] rbuf;
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take   <= 1'b0;
      rbuf   <= '0;
      sh     <= '0;
      sdo_oe <= 1'b0;
    end else begin
      take <= rd_en;
      if (take) rbuf <= rd_data;
      if (clr) begin
        sh     <= '0;
        sdo_oe <= 1'b0;
      end else if (fall) begin
        if (load_en && bit_zero) begin
          sh     <= rbuf;
          sdo_oe <= 1'b1;
        end else begin
          sh <= {sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo = sh[BYTE_W-1];
endmodule

// File: rtl/sercfg_port.sv
module sercfg_port
  import sercfg_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int DW    = BYTE_W,
  localparam int CNT_W = $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csn,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DW-1:0]     rd_data
);
  logic csn_s, sck_s, sdi_s, sck_d;
  logic sck_rise, sck_fall;

  sercfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({csn, sck, sdi}),
    .q     ({csn_s, sck_s, sdi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;

  logic             byte_ok;
  logic [DW-1:0]    byte_q;
  logic [CNT_W-1:0] bit_idx;
  phase_e           phase;

  sercfg_rx #(.BYTE_W(DW)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (csn_s),
    .rise    (sck_rise),
    .din     (sdi_s),
    .byte_ok (byte_ok),
    .byte_q  (byte_q),
    .bit_idx (bit_idx)
  );

  sercfg_seq #(.ADDR_W(ADDR_W), .BYTE_W(DW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (csn_s),
    .rise    (sck_rise),
    .byte_ok (byte_ok),
    .byte_q  (byte_q),
    .phase   (phase),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr)
  );

  sercfg_tx #(.BYTE_W(DW)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (csn_s),
    .fall     (sck_fall),
    .load_en  (phase == PH_RD),
    .bit_zero (bit_idx == '0),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
  );
endmodule

// File: rtl/sercfg_port_chk.sv
module sercfg_port_chk (
  input logic clk,
  input logic rst_n,
  input logic csn_s,
  input logic fall,
  input logic sdo,
  input logic sdo_oe,
  input logic wr_en,
  input logic rd_en
);
  AST_OE_OFF_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) csn_s |=> !sdo_oe); // R9
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en); // R5
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> !rd_en); // R7
  AST_NO_WR_DRIVING: assert property (@(posedge clk) disable iff (!rst_n) sdo_oe |-> !wr_en); // R10
  AST_NO_RD_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n) $past(csn_s) |-> !rd_en); // R11
  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sdo) |-> ($past(fall) || $past(csn_s))); // R8
endmodule

bind sercfg_port sercfg_port_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .csn_s  (csn_s),
  .fall   (sck_fall),
  .sdo    (sdo),
  .sdo_oe (sdo_oe),
  .wr_en  (wr_en),
  .rd_en  (rd_en)
);

// File: tb/sercfg_port_test.sv
module sercfg_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, wr_en, rd_en;
  logic [3:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  always #5 clk = ~clk;

  sercfg_port uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // register file model on the bench side
  logic [7:0] rf [16];
  always @(posedge clk) begin
    if (wr_en) rf[wr_addr] <= wr_data;
    if (rd_en) rd_data <= rf[rd_addr];
  end

  int nchk = 0, nfail = 0;
  bit started = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model, advanced at each serial edge
  logic [7:0]  ref_mem [16];
  logic [11:0] exp_wr [$];
  logic [3:0]  exp_rd [$];
  logic [7:0]  tx_q [$];
  int m_phase = 0, m_left = 0, m_bits = 0;
  logic [3:0] m_addr = 0, m_pa = 0;
  logic [7:0] m_sh = 0, m_pd = 0;
  bit m_active = 0, m_pend = 0;

  task automatic model_rise(input logic b);
    if (m_pend) begin
      exp_wr.push_back({m_pa, m_pd});
      ref_mem[m_pa] = m_pd;
      m_pend = 0;
    end
    if (m_active) begin
      m_sh = {m_sh[6:0], b};
      m_bits++;
      if (m_bits == 8) begin
        m_bits = 0;
        case (m_phase)
          0: begin
            m_addr = m_sh[3:0];
            m_left = int'(m_sh[6:4]);
            if (m_sh[7]) begin m_phase = 2; exp_rd.push_back(m_addr); end
            else m_phase = 1;
          end
          1: begin
            m_pend = 1; m_pa = m_addr; m_pd = m_sh; m_addr = m_addr + 4'd1;
            if (m_left == 0) m_phase = 3; else m_left--;
          end
          2: begin
            if (m_left == 0) m_phase = 3;
            else begin m_left--; m_addr = m_addr + 4'd1; exp_rd.push_back(m_addr); end
          end
          default: ;
        endcase
      end
    end
  endtask

  task automatic sample_check();
    if (m_active && m_phase == 2) begin
      chk(sdo_oe === 1'b1, "R9 oe in read", 32'(sdo_oe), 32'd1);
      chk(sdo === ref_mem[m_addr][7 - m_bits], "R8 sdo bit", 32'(sdo), 32'(ref_mem[m_addr][7 - m_bits]));
    end else if (m_active && m_phase == 0) begin
      chk(sdo_oe === 1'b0, "R9 oe in command", 32'(sdo_oe), 32'd0);
    end
  endtask

  task automatic run(input int nbits, input bit trail);
    csn = 1'b0; m_active = 1; m_phase = 0; m_bits = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      logic [7:0] cur;
      cur = (i / 8 < tx_q.size()) ? tx_q[i / 8] : 8'h00;
      sdi = cur[7 - (i % 8)];
      repeat (8) @(negedge clk);
      sample_check();
      sck = 1'b1;
      model_rise(sdi);
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    csn = 1'b1; m_active = 0;
    repeat (6) @(negedge clk);
    if (trail) begin
      sck = 1'b1; model_rise(1'b0);
      repeat (8) @(negedge clk);
      sck = 1'b0;
      repeat (8) @(negedge clk);
    end
    tx_q.delete();
  endtask

  // per-clock comparison of strobes and driver enable
  int cs_hi = 0;
  always @(negedge clk) begin
    if (started) begin
      if (wr_en) begin
        if (exp_wr.size() == 0) chk(1'b0, "R5 unexpected write", {20'd0, wr_addr, wr_data}, 32'hFFFF);
        else begin
          logic [11:0] e;
          e = exp_wr.pop_front();
          chk({wr_addr, wr_data} == e, "R5 write", {20'd0, wr_addr, wr_data}, {20'd0, e});
        end
      end
      if (rd_en) begin
        if (exp_rd.size() == 0) chk(1'b0, "R7 unexpected read", 32'(rd_addr), 32'hFF);
        else begin
          logic [3:0] e;
          e = exp_rd.pop_front();
          chk(rd_addr == e, "R7 read index", 32'(rd_addr), 32'(e));
        end
      end
      cs_hi = csn ? cs_hi + 1 : 0;
      if (cs_hi >= 5) chk(sdo_oe === 1'b0, "R9 oe with cs high", 32'(sdo_oe), 32'd0);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) begin rf[k] = 8'h00; ref_mem[k] = 8'h00; end
    repeat (3) @(negedge clk);
    chk(sdo_oe === 1'b0 && wr_en === 1'b0 && rd_en === 1'b0, "R1 in reset", {29'd0, sdo_oe, wr_en, rd_en}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdo_oe === 1'b0 && sdo === 1'b0 && wr_en === 1'b0 && rd_en === 1'b0, "R1 after reset",
        {28'd0, sdo_oe, sdo, wr_en, rd_en}, 32'd0);
    started = 1;

    // single write, index 3
    tx_q = '{8'h03, 8'hA5}; run(16, 1);
    chk(rf[3] == 8'hA5, "R2 decode write idx 3", 32'(rf[3]), 32'hA5);
    chk(rf[2] == 8'h00 && rf[4] == 8'h00, "R3 msb-first no spill", {16'd0, rf[2], rf[4]}, 32'd0);

    // three bytes from index 14, wraps to 0
    tx_q = '{8'h2E, 8'h11, 8'h22, 8'h33}; run(32, 1);
    chk(rf[14] == 8'h11 && rf[15] == 8'h22, "R6 increment", {16'd0, rf[14], rf[15]}, 32'h1122);
    chk(rf[0] == 8'h33, "R6 wrap to 0", 32'(rf[0]), 32'h33);

    // write left pending without trailing clock
    tx_q = '{8'h05, 8'h5A}; run(16, 0);
    repeat (20) @(negedge clk);
    chk(rf[5] == 8'h00, "R5 write waits for edge", 32'(rf[5]), 32'h00);

    // read 4 bytes from 14, junk on sdi; also commits the pending write
    tx_q = '{8'hBE, 8'hFF, 8'h0F, 8'hF0, 8'h85}; run(40, 1);
    chk(rf[5] == 8'h5A, "R5 pending committed", 32'(rf[5]), 32'h5A);
    chk(rf[1] == 8'h00 && rf[15] == 8'h22 && rf[14] == 8'h11, "R10 read ignores sdi",
        {8'd0, rf[1], rf[15], rf[14]}, 32'h002211);

    // read of the pending-written index
    tx_q = '{8'h85}; run(16, 1);

    // write beyond its count
    tx_q = '{8'h18, 8'h01, 8'h02, 8'h03}; run(32, 1);
    chk(rf[8] == 8'h01 && rf[9] == 8'h02, "R2 two-byte count", {16'd0, rf[8], rf[9]}, 32'h0102);
    chk(rf[10] == 8'h00, "R10 extra byte ignored", 32'(rf[10]), 32'h00);

    // abort inside the second data byte
    tx_q = '{8'h16, 8'hC3, 8'hF0}; run(20, 1);
    chk(rf[6] == 8'hC3, "R4 full byte kept", 32'(rf[6]), 32'hC3);
    chk(rf[7] == 8'h00, "R4 partial byte dropped", 32'(rf[7]), 32'h00);

    // abort inside a command, then a clean write
    tx_q = '{8'h8C}; run(5, 1);
    tx_q = '{8'h0C, 8'h7E}; run(16, 1);
    chk(rf[12] == 8'h7E, "R11 restart after abort", 32'(rf[12]), 32'h7E);

    // abort inside a read
    tx_q = '{8'h9E}; run(11, 1);
    repeat (10) @(negedge clk);
    chk(sdo_oe === 1'b0, "R9 oe off after read abort", 32'(sdo_oe), 32'd0);

    repeat (20) @(negedge clk);
    chk(exp_wr.size() == 0, "R5 all writes seen", 32'(exp_wr.size()), 32'd0);
    chk(exp_rd.size() == 0, "R7 all reads seen", 32'(exp_rd.size()), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule